// File: doc/BRIEF.md
# Serial Volume-Control Register Port

This block is the control front end of a stereo headphone volume controller. A host writes a 16-bit control word over three wires: a serial clock, a serial data line and a latch strobe. All three wires, and the two active-low control pins for mute and power-down, are brought into a fast system clock domain through synchronizers. Rising edges of the serial clock and the latch strobe are then found by edge detection in that domain.

Data bits enter a shift register most-significant bit first on each serial clock rising edge. A rising edge of the latch strobe copies the most recent 16 bits into the control outputs. The host may send more than 16 clocks; only the last 16 bits count. The upper four bits are ignored. The remaining bits select automatic gain control, one of three bass boost settings and one of two input pairs. An 8-bit attenuation code becomes a signed channel gain in dB, with a mute flag for codes past the end of the range.

The mute pin forces mute whatever the register holds, and also enables the beep path. The power-down pin drives a power-down output. All outputs are registered and go straight to the analog path.

Top module: `vol_ctrl_port`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and after it is released until the first latch, the outputs hold these values: `agc_en`=0, `boost_mode`=00, `in_sel`=0, `mute`=1, `gain_db`=-68 (0xBC).
- R2: Bits are shifted in on serial clock rising edges, first bit = bit 15 and last bit = bit 0. When more than 16 bits are sent before the latch edge, only the last 16 take effect.
- R3: Word bit 11 drives `agc_en` (1 = on).
- R4: Word bits {10,9} select `boost_mode`: 00 gives 00 (off), 01 gives 01 (response 1), 10 or 11 gives 10 (response 2). The value 11 never appears on `boost_mode`.
- R5: Word bit 8 drives `in_sel` (0 = input pair 1, 1 = input pair 2).
- R6: Word bits 7..0 form code C. For C from 0x00 to 0x50, `gain_db` is the two's-complement value 12-C. It spans +12 down to -68, and the code gives no mute.
- R7: For C from 0x51 to 0xFF, the code requests mute and `gain_db` reads -68.
- R8: While `mute_n` is low, `mute`=1 and `beep_en`=1, and `gain_db` keeps the latched value. When the pin returns high, `mute` follows the latched code again and `beep_en`=0.
- R9: `pwr_down` is 1 while `pwdn_n` is low and 0 while it is high.
- R10: Word bits 15..12 have no effect on any output.
- R11: Serial clocks and data with no latch rising edge leave every output unchanged.
- R12: Register outputs change only in the system clock cycle after a latch edge is detected. Pin-driven outputs follow their synchronized pins one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the fastest serial edge rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe, loads on rising edge |
| mute_n | input | 1 | Active-low mute pin |
| pwdn_n | input | 1 | Active-low power-down pin |
| agc_en | output | 1 | Automatic gain control enable |
| boost_mode | output | 2 | Bass boost: 00 off, 01 response 1, 10 response 2 |
| in_sel | output | 1 | Input pair select |
| gain_db | output | 8 | Signed channel gain in dB |
| mute | output | 1 | Channel mute |
| beep_en | output | 1 | Beep path enable |
| pwr_down | output | 1 | Power-down request |

## Verification
Words are chosen so that each field decodes to a value that a bit-reversed or shifted capture would not produce. For example, 0x0801 separates MSB-first from LSB-first order. A 20-bit burst shows whether the oldest or the newest 16 bits are kept. Attenuation codes 0x00, 0x50, 0x51 and 0xFF sit on both sides of the mute boundary. All four boost encodings are covered, including the redundant 11. A word with the upper nibble set is compared against the same word with the nibble clear. Serial clocking without a latch edge, pin-only mute and power-down, and a reset in the middle of the run each show whether outputs move only for the cause that owns them.

// File: rtl/volc_pkg.sv
package volc_pkg;

   typedef enum logic [1:0] {
      BOOST_OFF = 2'b00,
      BOOST_R1  = 2'b01,
      BOOST_R2  = 2'b10
   } boost_e;

   localparam int AGC_BIT   = 11;
   localparam int BOOST_MSB = 10;
   localparam int BOOST_LSB = 9;
   localparam int SEL_BIT   = 8;

endpackage

// File: rtl/volc_sync.sv
module volc_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/volc_shifter.sv
module volc_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              le_s,
   output logic [WORD_W-1:0] word,
   output logic              le_rise
);
   logic sclk_d;
   logic le_d;
   logic sclk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b1;
         le_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         le_d   <= le_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign le_rise   = le_s & ~le_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word <= '0;
      else if (sclk_rise) word <= {word[WORD_W-2:0], sdat_s};
   end
endmodule

// File: rtl/volc_decode.sv
module volc_decode
   import volc_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ATT_W     = 8,
   parameter int GAIN_W    = 8,
   parameter int MAX_GAIN  = 12,
   parameter int LAST_CODE = 80
) (
   input  logic [WORD_W-1:0] word,
   output logic              agc,
   output boost_e            boost,
   output logic              sel,
   output logic [GAIN_W-1:0] gain,
   output logic              code_mute
);
   localparam int FLOOR = MAX_GAIN - LAST_CODE;

   logic [ATT_W-1:0] code;
   logic             unused_hi;

   assign code      = word[ATT_W-1:0];
   assign unused_hi = ^word[WORD_W-1:AGC_BIT+1];
   assign agc       = word[AGC_BIT];
   assign sel       = word[SEL_BIT];

   always_comb begin
      if (word[BOOST_MSB])      boost = BOOST_R2;
      else if (word[BOOST_LSB]) boost = BOOST_R1;
      else                      boost = BOOST_OFF;
   end

   always_comb begin
      if (int'(code) > LAST_CODE) begin
         code_mute = 1'b1;
         gain      = GAIN_W'(FLOOR);
      end else begin
         code_mute = 1'b0;
         gain      = GAIN_W'(MAX_GAIN - int'(code));
      end
   end
endmodule

// File: rtl/vol_ctrl_port.sv
module vol_ctrl_port
   import volc_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int ATT_W       = 8,
   parameter int GAIN_W      = 8,
   parameter int MAX_GAIN    = 12,
   parameter int LAST_CODE   = 80,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              ser_le,
   input  logic              mute_n,
   input  logic              pwdn_n,
   output logic              agc_en,
   output logic [1:0]        boost_mode,
   output logic              in_sel,
   output logic [GAIN_W-1:0] gain_db,
   output logic              mute,
   output logic              beep_en,
   output logic              pwr_down
);
   localparam int FLOOR  = MAX_GAIN - LAST_CODE;
   localparam int N_PINS = 5;

   generate
      if (WORD_W <= AGC_BIT) begin : g_bad_word
         $error("WORD_W too small for control fields");
      end
      if (ATT_W > SEL_BIT) begin : g_bad_att
         $error("attenuation field overlaps select bit");
      end
      if (LAST_CODE >= (1 << ATT_W)) begin : g_bad_code
         $error("LAST_CODE does not fit in ATT_W");
      end
      if (MAX_GAIN >= (1 << (GAIN_W-1)) || FLOOR < -(1 << (GAIN_W-1))) begin : g_bad_gain
         $error("GAIN_W too narrow for gain range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [N_PINS-1:0] pins_s;
   logic              sclk_s, sdat_s, le_s, mute_n_s, pwdn_n_s;

   volc_sync #(.STAGES(SYNC_STAGES), .W(N_PINS), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_dat, ser_le, mute_n, pwdn_n}),
      .q     (pins_s)
   );
   assign {sclk_s, sdat_s, le_s, mute_n_s, pwdn_n_s} = pins_s;

   logic [WORD_W-1:0] shift_word;
   logic              le_rise;

   volc_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .sdat_s  (sdat_s),
      .le_s    (le_s),
      .word    (shift_word),
      .le_rise (le_rise)
   );

   logic              d_agc, d_sel, d_mute;
   boost_e            d_boost;
   logic [GAIN_W-1:0] d_gain;

   volc_decode #(
      .WORD_W(WORD_W), .ATT_W(ATT_W), .GAIN_W(GAIN_W),
      .MAX_GAIN(MAX_GAIN), .LAST_CODE(LAST_CODE)
   ) u_dec (
      .word      (shift_word),
      .agc       (d_agc),
      .boost     (d_boost),
      .sel       (d_sel),
      .gain      (d_gain),
      .code_mute (d_mute)
   );

   logic   code_mute_q;
   boost_e boost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         agc_en      <= 1'b0;
         boost_q     <= BOOST_OFF;
         in_sel      <= 1'b0;
         gain_db     <= GAIN_W'(FLOOR);
         code_mute_q <= 1'b1;
      end else if (le_rise) begin
         agc_en      <= d_agc;
         boost_q     <= d_boost;
         in_sel      <= d_sel;
         gain_db     <= d_gain;
         code_mute_q <= d_mute;
      end
   end

   assign boost_mode = boost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mute     <= 1'b1;
         beep_en  <= 1'b0;
         pwr_down <= 1'b0;
      end else begin
         mute     <= (le_rise ? d_mute : code_mute_q) | ~mute_n_s;
         beep_en  <= ~mute_n_s;
         pwr_down <= ~pwdn_n_s;
      end
   end
endmodule

// File: rtl/volc_chk.sv
module volc_chk #(
   parameter int WORD_W    = 16,
   parameter int ATT_W     = 8,
   parameter int GAIN_W    = 8,
   parameter int MAX_GAIN  = 12,
   parameter int LAST_CODE = 80
) (
   input logic              clk,
   input logic              rst_n,
   input logic              le_rise,
   input logic [WORD_W-1:0] word,
   input logic              mute_n_s,
   input logic              pwdn_n_s,
   input logic              agc_en,
   input logic [1:0]        boost_mode,
   input logic              in_sel,
   input logic [GAIN_W-1:0] gain_db,
   input logic              mute,
   input logic              beep_en,
   input logic              pwr_down
);
   localparam int FLOOR = MAX_GAIN - LAST_CODE;

   a_r4_boost_legal: assert property (@(posedge clk) disable iff (!rst_n)
      boost_mode != 2'b11);

   a_r6_gain_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(gain_db) <= MAX_GAIN) && ($signed(gain_db) >= FLOOR));

   a_r7_high_code_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (le_rise && (int'(word[ATT_W-1:0]) > LAST_CODE))
      |=> (mute && gain_db == GAIN_W'(FLOOR)));

   a_r8_pin_mute: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_n_s |=> (mute && beep_en));

   a_r9_pwdn_on: assert property (@(posedge clk) disable iff (!rst_n)
      !pwdn_n_s |=> pwr_down);

   a_r9_pwdn_off: assert property (@(posedge clk) disable iff (!rst_n)
      pwdn_n_s |=> !pwr_down);

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !le_rise |=> ($stable(agc_en) && $stable(boost_mode)
                    && $stable(in_sel) && $stable(gain_db)));
endmodule

bind vol_ctrl_port volc_chk #(
   .WORD_W(WORD_W), .ATT_W(ATT_W), .GAIN_W(GAIN_W),
   .MAX_GAIN(MAX_GAIN), .LAST_CODE(LAST_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .le_rise    (le_rise),
   .word       (shift_word),
   .mute_n_s   (mute_n_s),
   .pwdn_n_s   (pwdn_n_s),
   .agc_en     (agc_en),
   .boost_mode (boost_mode),
   .in_sel     (in_sel),
   .gain_db    (gain_db),
   .mute       (mute),
   .beep_en    (beep_en),
   .pwr_down   (pwr_down)
);

// File: tb/sim_vol_ctrl_port.sv
module sim_vol_ctrl_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic mute_n = 1'b1, pwdn_n = 1'b1;
   logic       agc_en, in_sel, mute, beep_en, pwr_down;
   logic [1:0] boost_mode;
   logic [7:0] gain_db;

   always #5 clk = ~clk;

   vol_ctrl_port u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .mute_n(mute_n), .pwdn_n(pwdn_n),
      .agc_en(agc_en), .boost_mode(boost_mode), .in_sel(in_sel),
      .gain_db(gain_db), .mute(mute), .beep_en(beep_en), .pwr_down(pwr_down)
   );

   typedef struct {
      string      req;
      logic [14:0] val;
   } item_t;

   item_t exp_q[$];
   event  chk_ev;
   int    checks = 0;
   int    failures = 0;
   bit    done = 0;

   logic [15:0] last_word = 16'h0000;
   bit          code_mute_m = 1'b1;
   bit          latched = 0;

   function automatic logic [14:0] pack(logic a, logic [1:0] b, logic s,
                                        logic [7:0] g, logic m, logic be, logic pd);
      return {a, b, s, g, m, be, pd};
   endfunction

   function automatic logic [14:0] model(logic [15:0] w);
      int code;
      logic [1:0] b;
      logic [7:0] g;
      bit cm;
      code = int'(w[7:0]);
      b  = w[10] ? 2'b10 : (w[9] ? 2'b01 : 2'b00);
      cm = (code > 80);
      g  = cm ? 8'(-68) : 8'(12 - code);
      if (!latched) return pack(0, 2'b00, 0, 8'(-68), 1'b1 | ~mute_n, ~mute_n, ~pwdn_n);
      return pack(w[11], b, w[8], g, cm | ~mute_n, ~mute_n, ~pwdn_n);
   endfunction

   task automatic expect_now(string req);
      item_t it;
      it.req = req;
      it.val = model(last_word);
      exp_q.push_back(it);
      ->chk_ev;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_bits(logic [31:0] v, int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = v[i];
         repeat (6) @(negedge clk);
         ser_clk = 1'b1;
         repeat (6) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic latch_pulse();
      ser_le = 1'b1;
      repeat (8) @(negedge clk);
      ser_le = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic write_word(logic [15:0] w, string req);
      send_bits({16'h0, w}, 16);
      latch_pulse();
      last_word = w;
      latched = 1;
      expect_now(req);
   endtask

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(chk_ev);
         @(negedge clk);
         if (exp_q.size() != 0) begin
            item_t it;
            logic [14:0] act;
            it  = exp_q.pop_front();
            act = pack(agc_en, boost_mode, in_sel, gain_db, mute, beep_en, pwr_down);
            checks++;
            if (act !== it.val) begin
               failures++;
               $display("FAIL %s: got agc/boost/sel/gain/mute/beep/pd=%b_%b_%b_%h_%b_%b_%b expected %b_%b_%b_%h_%b_%b_%b",
                        it.req, act[14], act[13:12], act[11], act[10:3], act[2], act[1], act[0],
                        it.val[14], it.val[13:12], it.val[11], it.val[10:3], it.val[2], it.val[1], it.val[0]);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      expect_now("R1 during reset");
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      expect_now("R1 after release");

      write_word(16'h0000, "R6 code 0x00 gives +12");
      write_word(16'h0801, "R3 agc on, R2 msb-first order");
      write_word(16'h0205, "R4 boost 01");
      write_word(16'h0400, "R4 boost 10");
      write_word(16'h0600, "R4 boost 11 maps to 10");
      write_word(16'h0150, "R5 input pair 2, R6 code 0x50 gives -68");
      write_word(16'h0051, "R7 code 0x51 mutes");
      write_word(16'h00FF, "R7 code 0xFF mutes");
      write_word(16'hF00A, "R10 upper nibble ignored");

      // R2: 20-bit burst, only the newest 16 bits count
      send_bits(32'h000F_0003, 20);
      latch_pulse();
      last_word = 16'h0003;
      expect_now("R2 long burst keeps last 16");

      write_word(16'h0014, "R6 code 0x14 gives -8");
      // R11: clocking without a latch edge
      send_bits({16'h0, 16'h0BFF}, 16);
      expect_now("R11 no latch, no change");

      mute_n = 1'b0;
      repeat (8) @(negedge clk);
      expect_now("R8 pin mute forces mute and beep");
      mute_n = 1'b1;
      repeat (8) @(negedge clk);
      expect_now("R8 pin release restores");

      pwdn_n = 1'b0;
      repeat (8) @(negedge clk);
      expect_now("R9 power-down asserted");
      pwdn_n = 1'b1;
      repeat (8) @(negedge clk);
      expect_now("R9 power-down released");

      rst_n = 1'b0;
      latched = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      expect_now("R1 mid-run reset");

      repeat (10) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule